// File: doc/BRIEF.md
# Coin-Accumulating Dispense Controller

This block is a small Moore state machine that guards the release latch of a drink dispenser. One serving costs 15 cents. A coin sensor upstream produces a single-cycle pulse on one of two inputs, one for a 5-cent coin and one for a 10-cent coin. The controller adds each coin to a running credit. When the credit reaches 15 cents, it raises an output that opens the release mechanism.

Credit is held in four states: 0, 5, 10 and 15 cents. A dime inserted at 10 cents still lands on 15, so the extra 5 cents is kept and no change is returned. Once the credit reaches 15, the controller stays there and keeps the latch open until the surrounding system applies reset, which starts the next sale. Control logic turns the coin pulses into step strobes. A datapath holds the credit register and the registered open flag.

Top module: `coin_vend_fsm`

## Requirements
- R1: A synchronous, active-high reset puts the credit at 0 cents (code 00) and drives the open output low on the next clock edge, from any state.
- R2: In a cycle with no coin pulse, the credit keeps its value.
- R3: Below 15 cents, a nickel adds 5 cents. At 0 or 5 cents, a dime adds 10 cents.
- R4: At 10 cents, either a nickel or a dime moves the credit to exactly 15 cents. The surplus is not returned.
- R5: At 15 cents, the credit and the open output stay unchanged whatever coins arrive, until reset.
- R6: When nickel and dime pulse in the same cycle, only the dime is counted.
- R7: Open is high exactly when the credit is 15 cents (code 11). It is registered and rises on the same clock edge that brings the credit to 15.
- R8: In cycles without simultaneous coins, the credit bits Q1Q0 (encoding 0/5/10/15 cents = 00/01/10/11) follow Q1+ = Q1 | D | Q0&N and Q0+ = ~Q0&N | Q0&~N | Q1&N | Q1&D.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| coinNickel | input | 1 | One-cycle pulse per 5-cent coin |
| coinDime | input | 1 | One-cycle pulse per 10-cent coin |
| dispenseOpen | output | 1 | High while credit is 15 cents; opens the release |

## Verification
The assertions assume only that reset is sampled on the clock and that the coin inputs are settled at each edge. Simultaneous nickel and dime pulses are allowed, and the equation check leaves that case out, because the priority rule decides it. The stimulus drives coins on the falling edge, one pattern per cycle. It sweeps every sequence of four cycles drawn from no coin, nickel, dime and both, starting each from reset, so every state is entered with every input combination.

// File: rtl/vend_pkg.sv
package vend_pkg;
  typedef struct packed {
    logic stepOne;
    logic stepTwo;
  } step_strobe_t;
endpackage

// File: rtl/vend_control.sv
module vend_control
  import vend_pkg::*;
#(
  parameter int CREDIT_W = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                coinNickel,
  input  logic                coinDime,
  input  logic [CREDIT_W-1:0] creditQ,
  output step_strobe_t        strobe
);
  logic isFull;

  always_comb begin
    isFull = &creditQ;
    strobe.stepTwo = coinDime & ~isFull;
    strobe.stepOne = coinNickel & ~coinDime & ~isFull;
  end

  // R6
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strobe.stepOne, strobe.stepTwo}));
endmodule

// File: rtl/vend_datapath.sv
module vend_datapath
  import vend_pkg::*;
#(
  parameter int CREDIT_W = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  step_strobe_t        strobe,
  output logic [CREDIT_W-1:0] creditQ,
  output logic                openQ
);
  localparam logic [CREDIT_W-1:0] FULL = '1;
  localparam int SUM_W = CREDIT_W + 1;

  logic [SUM_W-1:0]    inc;
  logic [SUM_W-1:0]    sum;
  logic [CREDIT_W-1:0] creditNext;

  always_comb begin
    inc = '0;
    if (strobe.stepTwo)      inc = SUM_W'(2);
    else if (strobe.stepOne) inc = SUM_W'(1);
    sum = {1'b0, creditQ} + inc;
    creditNext = (sum > {1'b0, FULL}) ? FULL : sum[CREDIT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      creditQ <= '0;
      openQ   <= 1'b0;
    end else begin
      creditQ <= creditNext;
      openQ   <= (creditNext == FULL);
    end
  end

  // R5
  full_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (creditQ == FULL) |=> (creditQ == FULL) && openQ);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (creditQ == '0) && !openQ);
endmodule

// File: rtl/coin_vend_fsm.sv
module coin_vend_fsm
  import vend_pkg::*;
#(
  parameter int CREDIT_W = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic coinNickel,
  input  logic coinDime,
  output logic dispenseOpen
);
  logic [CREDIT_W-1:0] creditQ;
  step_strobe_t        strobe;

  vend_control #(.CREDIT_W(CREDIT_W)) u_ctrl (
    .clk(clk), .rst(rst), .coinNickel(coinNickel), .coinDime(coinDime),
    .creditQ(creditQ), .strobe(strobe)
  );

  vend_datapath #(.CREDIT_W(CREDIT_W)) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .creditQ(creditQ), .openQ(dispenseOpen)
  );

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!coinNickel && !coinDime) |=> $stable(creditQ));

  // R7
  open_moore_chk: assert property (@(posedge clk) disable iff (rst)
    dispenseOpen == (&creditQ));

  generate
    if (CREDIT_W == 2) begin : g_eq
      // R8
      next_eq_chk: assert property (@(posedge clk) disable iff (rst)
        !(coinNickel && coinDime) |=>
          creditQ == {$past(creditQ[1] | coinDime | (creditQ[0] & coinNickel)),
                      $past((~creditQ[0] & coinNickel) | (creditQ[0] & ~coinNickel) |
                            (creditQ[1] & coinNickel) | (creditQ[1] & coinDime))});
    end
  endgenerate
endmodule

// File: tb/tb_coin_vend_fsm.sv
module tb_coin_vend_fsm;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic coinNickel = 1'b0;
  logic coinDime = 1'b0;
  logic dispenseOpen;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  coin_vend_fsm dut (
    .clk(clk), .rst(rst), .coinNickel(coinNickel), .coinDime(coinDime),
    .dispenseOpen(dispenseOpen)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: open=%b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1; coinNickel = 1'b0; coinDime = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    check("R1 reset", dispenseOpen, 1'b0);
  endtask

  initial begin
    #1600000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    doReset();
    // Exhaustive sweep: 4 cycles, each none/N/D/both (code bit0=N, bit1=D)
    for (int seq = 0; seq < 256; seq++) begin
      int credit;
      doReset();
      credit = 0;
      for (int step = 0; step < 4; step++) begin
        int pat;
        string tag;
        pat = (seq >> (2 * step)) & 3;
        if (credit == 15)     tag = "R5";
        else if (pat == 3)    tag = "R6";
        else if (pat == 0)    tag = "R2";
        else if (credit == 10) tag = "R4";
        else                  tag = "R3";
        coinNickel = pat[0];
        coinDime   = pat[1];
        if (pat[1])      credit = credit + 10;
        else if (pat[0]) credit = credit + 5;
        if (credit > 15) credit = 15;
        @(negedge clk);
        coinNickel = 1'b0; coinDime = 1'b0;
        check({tag, " R7 R8"}, dispenseOpen, credit == 15);
      end
    end
    // R1: reset out of the full state
    doReset();
    coinDime = 1'b1; @(negedge clk);
    coinNickel = 1'b1; coinDime = 1'b0; @(negedge clk);
    coinNickel = 1'b0;
    check("R4 R7 dime+nickel", dispenseOpen, 1'b1);
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    check("R1 reset from full", dispenseOpen, 1'b0);
    // R5: long hold with coins
    coinDime = 1'b1; @(negedge clk);
    coinDime = 1'b0; coinNickel = 1'b1; @(negedge clk);
    coinNickel = 1'b0;
    for (int k = 0; k < 20; k++) begin
      coinNickel = k[0]; coinDime = k[1];
      @(negedge clk);
      check("R5 hold", dispenseOpen, 1'b1);
    end
    coinNickel = 1'b0; coinDime = 1'b0;
    // R2: idle at 5 cents for many cycles, then a dime completes
    doReset();
    coinNickel = 1'b1; @(negedge clk); coinNickel = 1'b0;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      check("R2 idle", dispenseOpen, 1'b0);
    end
    coinDime = 1'b1; @(negedge clk); coinDime = 1'b0;
    check("R3 R7 nickel+dime", dispenseOpen, 1'b1);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule